// File: doc/BRIEF.md
# Event-Triggered Register Field Loader

This block is a small register bank on a single-cycle memory-mapped strobe bus. Each access is a one-cycle pulse on `bus_sel`, with `bus_wr` choosing write or read. Every field can be written and read back directly. Several fields also take a new value without being written. Such a load happens when software reads or writes a *different* register of the bank. The loaded value comes either from a hardware input port or from another field of the same width.

The bank has three kinds of conditional load:

- **Plain hardware and field loads.** One field loads from a hardware input, and another loads from a field.
- **Cross-loading pair.** Two fields load each other's current value, each on the other's access.
- **Repeated register array.** Exactly one iteration, chosen by a parameter, is the target of a hardware load. The index that selects it is the index of the repeated register itself. The other iterations keep their values.

Read data is combinational and valid while the read strobe is high. It shows the field as it stood before any load that the same read triggers. Loaded values are visible from the clock cycle after the triggering access.

Top module: `evcond_regbank`

Address map (word addresses, 4-bit address):

| Address | Register | Conditional load |
|---|---|---|
| 0 | LOADA | loads `hw_in_a` on a write to 4 |
| 1 | COPYB | loads the LOADA value on a read of 4 |
| 2 | PAIRX | loads the PAIRY value on a read of 3 |
| 3 | PAIRY | loads the PAIRX value on a write to 2 |
| 4 | SCRATCH | none |
| 8 .. 8+NREP-1 | ARR[i] | ARR[TGT_IDX] loads `hw_in_arr` on a read of 0 |

## Requirements
- R1: While reset is asserted (active-low, asynchronous), every field clears to zero.
- R2: A write to a mapped address (0 to 4, or 8+i for i below NREP) stores `bus_wdata`. A read of it returns the stored value on `bus_rdata` in the same cycle as the strobe.
- R3: A read of an unmapped address (5 to 7, or 8+NREP upward) returns zero. A write to one changes no field.
- R4: A write to address 4 makes field 0 equal `hw_in_a`, as sampled in the write cycle, from the following cycle on.
- R5: A read of address 4 makes field 1 equal the value that field 0 held in the read cycle, from the following cycle on.
- R6: A read of address 3 makes field 2 take field 3's value. A write to address 2 stores the written data in field 2 and makes field 3 take field 2's previous value. Both take effect from the next cycle.
- R7: A read of address 0 makes array iteration TGT_IDX (address 8+TGT_IDX) take `hw_in_arr` from the next cycle on. Every other array iteration keeps its value.
- R8: A read whose event triggers a load into any field returns the pre-load contents of the register being read.
- R9: When a direct write and a conditional load hit the same field in one cycle, the written data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | One-cycle access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read (valid with `bus_sel`) |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational during a read strobe, zero otherwise |
| hw_in_a | input | DW | Hardware source for field 0 |
| hw_in_arr | input | DW | Hardware source for the targeted array iteration |

## Verification
Read data belongs to the strobe cycle itself. The bench therefore samples `bus_rdata` a little after it drives the strobe, before the next rising edge. Every conditional load lands at the first rising edge after the triggering access. So the first access issued afterwards, one cycle later, must already see the new value, and every following read re-checks it. A reference image of all sixteen addresses is updated after each access from the requirement rules, using the values held before that access. Every read is compared against this image, so pre-load read data and the unchanged array iterations are checked on every access.

// File: rtl/evcond_pkg.sv
package evcond_pkg;

    // Address map of the bank (word addresses)
    localparam int A_LOADA   = 0;
    localparam int A_COPYB   = 1;
    localparam int A_PAIRX   = 2;
    localparam int A_PAIRY   = 3;
    localparam int A_SCRATCH = 4;
    localparam int A_ARRBASE = 8;

    // Field indices inside the flat field vector
    localparam int F_LOADA   = 0;
    localparam int F_COPYB   = 1;
    localparam int F_PAIRX   = 2;
    localparam int F_PAIRY   = 3;
    localparam int F_SCRATCH = 4;
    localparam int F_ARR0    = 5;

    // Word address of field k
    function automatic int fld_addr(input int k);
        return (k < F_ARR0) ? k : (A_ARRBASE + k - F_ARR0);
    endfunction

    // True when address a belongs to a field
    function automatic logic addr_mapped(input int a, input int nrep);
        return (a < F_ARR0) || ((a >= A_ARRBASE) && (a < A_ARRBASE + nrep));
    endfunction

endpackage

// File: rtl/evcond_evt_decode.sv
module evcond_evt_decode #(
    parameter int AW = 4,
    localparam int NA = 1 << AW
) (
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    output logic [NA-1:0] rd_ev,
    output logic [NA-1:0] wr_ev
);

    // One-hot event vectors: one read and one write event per address
    always_comb begin
        rd_ev = '0;
        wr_ev = '0;
        if (bus_sel) begin
            if (bus_wr) begin
                wr_ev[bus_addr] = 1'b1;
            end else begin
                rd_ev[bus_addr] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/evcond_field.sv
module evcond_field #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          ld_en,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] q
);

    // A direct write outranks the event-conditioned load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wr_data;
        end else if (ld_en) begin
            q <= ld_val;
        end
    end

endmodule

// File: rtl/evcond_rd_mux.sv
module evcond_rd_mux #(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter int NF = 9,
    localparam int NA = 1 << AW
) (
    input  logic [NA-1:0]         rd_ev,
    input  logic [NF-1:0][DW-1:0] fld_q,
    output logic [DW-1:0]         rdata
);

    logic [NF-1:0][DW-1:0] term;

    // Each field drives its current value only when its own read event is high
    for (genvar k = 0; k < NF; k++) begin : g_term
        localparam logic [AW-1:0] ADDR_K = AW'(evcond_pkg::fld_addr(k));
        assign term[k] = rd_ev[ADDR_K] ? fld_q[k] : '0;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NF; k++) begin
            rdata = rdata | term[k];
        end
    end

endmodule

// File: rtl/evcond_regbank.sv
module evcond_regbank #(
    parameter int AW      = 4,
    parameter int DW      = 8,
    parameter int NREP    = 4,
    parameter int TGT_IDX = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] hw_in_a,
    input  logic [DW-1:0] hw_in_arr
);
    import evcond_pkg::*;

    localparam int NA = 1 << AW;
    localparam int NF = F_ARR0 + NREP;

    logic [NA-1:0]         rd_ev;
    logic [NA-1:0]         wr_ev;
    logic [NF-1:0]         wr_en;
    logic [NF-1:0]         ld_en;
    logic [NF-1:0][DW-1:0] ld_val;
    logic [NF-1:0][DW-1:0] fld_q;

    evcond_evt_decode #(.AW(AW)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .rd_ev    (rd_ev),
        .wr_ev    (wr_ev)
    );

    // Conditional load sources and triggers (events at other addresses)
    always_comb begin
        ld_en  = '0;
        ld_val = '0;
        ld_en[F_LOADA]  = wr_ev[A_SCRATCH];
        ld_val[F_LOADA] = hw_in_a;
        ld_en[F_COPYB]  = rd_ev[A_SCRATCH];
        ld_val[F_COPYB] = fld_q[F_LOADA];
        ld_en[F_PAIRX]  = rd_ev[A_PAIRY];
        ld_val[F_PAIRX] = fld_q[F_PAIRY];
        ld_en[F_PAIRY]  = wr_ev[A_PAIRX];
        ld_val[F_PAIRY] = fld_q[F_PAIRX];
        for (int i = 0; i < NREP; i++) begin
            if (i == TGT_IDX) begin
                ld_en[F_ARR0+i]  = rd_ev[A_LOADA];
                ld_val[F_ARR0+i] = hw_in_arr;
            end
        end
    end

    for (genvar k = 0; k < NF; k++) begin : g_fld
        localparam logic [AW-1:0] ADDR_K = AW'(fld_addr(k));
        assign wr_en[k] = wr_ev[ADDR_K];
        evcond_field #(.DW(DW)) u_fld (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[k]),
            .wr_data (bus_wdata),
            .ld_en   (ld_en[k]),
            .ld_val  (ld_val[k]),
            .q       (fld_q[k])
        );
    end

    evcond_rd_mux #(.AW(AW), .DW(DW), .NF(NF)) u_mux (
        .rd_ev (rd_ev),
        .fld_q (fld_q),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/evcond_chk.sv
module evcond_chk #(
    parameter int AW      = 4,
    parameter int DW      = 8,
    parameter int NREP    = 4,
    parameter int TGT_IDX = 2,
    localparam int NF = evcond_pkg::F_ARR0 + NREP
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [AW-1:0]         bus_addr,
    input logic [DW-1:0]         bus_wdata,
    input logic [DW-1:0]         bus_rdata,
    input logic [DW-1:0]         hw_in_a,
    input logic [DW-1:0]         hw_in_arr,
    input logic [NF-1:0][DW-1:0] fld_q
);
    import evcond_pkg::*;

    logic wr_any, rd_any;
    assign wr_any = bus_sel && bus_wr;
    assign rd_any = bus_sel && !bus_wr;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> fld_q == '0); // R1

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && !addr_mapped(int'(bus_addr), NREP)) |-> bus_rdata == '0); // R3

    AST_LOADA_FROM_HW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == AW'(A_SCRATCH)) |=> fld_q[F_LOADA] == $past(hw_in_a)); // R4

    AST_COPYB_FROM_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && bus_addr == AW'(A_SCRATCH)) |=> fld_q[F_COPYB] == $past(fld_q[F_LOADA])); // R5

    AST_PAIRX_FROM_Y: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && bus_addr == AW'(A_PAIRY)) |=> fld_q[F_PAIRX] == $past(fld_q[F_PAIRY])); // R6

    AST_PAIRY_FROM_X: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == AW'(A_PAIRX)) |=> fld_q[F_PAIRY] == $past(fld_q[F_PAIRX])); // R6

    AST_PAIRX_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == AW'(A_PAIRX)) |=> fld_q[F_PAIRX] == $past(bus_wdata)); // R9

    AST_ARR_TARGET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && bus_addr == AW'(A_LOADA)) |=> fld_q[F_ARR0+TGT_IDX] == $past(hw_in_arr)); // R7

    for (genvar i = 0; i < NREP; i++) begin : g_arr
        if (i != TGT_IDX) begin : g_other
            AST_ARR_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_any && bus_addr == AW'(A_ARRBASE + i)) |=> $stable(fld_q[F_ARR0+i])); // R7
        end
    end

    AST_READ_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && bus_addr == AW'(A_LOADA)) |-> bus_rdata == fld_q[F_LOADA]); // R8

endmodule

bind evcond_regbank evcond_chk #(
    .AW(AW), .DW(DW), .NREP(NREP), .TGT_IDX(TGT_IDX)
) u_chk (.*);

// File: tb/evcond_regbank_tb.sv
module evcond_regbank_tb_top;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NREP = 4;
    localparam int TGT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] hw_in_a = '0;
    logic [DW-1:0] hw_in_arr = '0;

    int vecs = 0;
    int bad = 0;
    logic [DW-1:0] mdl [16];

    always #10 clk = ~clk;

    evcond_regbank #(.AW(AW), .DW(DW), .NREP(NREP), .TGT_IDX(TGT)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_in_a   (hw_in_a),
        .hw_in_arr (hw_in_arr)
    );

    function automatic bit mapped(input int a);
        return (a < 5) || (a >= 8 && a < 8 + NREP);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus access; a read is compared against the reference image,
    // then the image advances by the requirement rules using old values.
    task automatic op(input logic wr, input int a, input logic [DW-1:0] d, input string req);
        logic [DW-1:0] old [16];
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a[AW-1:0]; bus_wdata = d;
        #2;
        if (!wr) check(req, bus_rdata, mdl[a]);
        old = mdl;
        if (wr && mapped(a)) mdl[a] = d;                  // R2, R3, R9
        if (wr && a == 4) mdl[0] = hw_in_a;               // R4
        if (!wr && a == 4) mdl[1] = old[0];               // R5
        if (!wr && a == 3) mdl[2] = old[3];               // R6
        if (wr && a == 2) mdl[3] = old[2];                // R6
        if (!wr && a == 0) mdl[8 + TGT] = hw_in_arr;      // R7
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 16; a++) op(1'b0, a, '0, req);
    endtask

    initial begin
        for (int a = 0; a < 16; a++) mdl[a] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R3: every address reads zero after reset
        read_all("R1");

        // R2: write/readback sweep over all addresses (unmapped must stay zero: R3)
        for (int p = 0; p < 3; p++) begin
            for (int a = 0; a < 16; a++) op(1'b1, a, DW'(a * 37 + p * 91 + 5), "R2");
            read_all("R2");
        end

        // R4: write to SCRATCH loads field 0 from hw_in_a, next access sees it
        for (int v = 0; v < 16; v++) begin
            hw_in_a = DW'(v * 17 + 3);
            op(1'b1, 4, DW'(v), "R4");
            hw_in_a = ~hw_in_a;
            op(1'b0, 0, '0, "R4");
        end

        // R5: read of SCRATCH copies field 0 into field 1
        for (int v = 0; v < 8; v++) begin
            op(1'b1, 0, DW'(v * 29 + 1), "R5");
            op(1'b0, 4, '0, "R5");
            op(1'b0, 1, '0, "R5");
        end

        // R6 / R8 / R9: cross-loading pair
        for (int v = 0; v < 8; v++) begin
            op(1'b1, 3, DW'(v * 13 + 7), "R6");
            op(1'b0, 3, '0, "R8");
            op(1'b0, 2, '0, "R6");
            op(1'b1, 2, DW'(v * 41 + 2), "R9");
            op(1'b0, 2, '0, "R9");
            op(1'b0, 3, '0, "R6");
        end

        // R7 / R8: read of field 0 loads only the targeted array iteration
        for (int v = 0; v < 8; v++) begin
            for (int i = 0; i < NREP; i++) op(1'b1, 8 + i, DW'(v * 7 + i * 50), "R7");
            hw_in_arr = DW'(v * 31 + 200);
            op(1'b0, 0, '0, "R8");
            hw_in_arr = ~hw_in_arr;
            for (int i = 0; i < NREP; i++) op(1'b0, 8 + i, '0, "R7");
        end

        // R3: unmapped writes alter nothing
        for (int a = 5; a < 8; a++) op(1'b1, a, 8'hA5, "R3");
        for (int a = 8 + NREP; a < 16; a++) op(1'b1, a, 8'h5A, "R3");
        read_all("R3");

        // R1: assert reset mid-run, everything clears
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a++) mdl[a] = '0;
        read_all("R1");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule